// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap FIR filter rebuilt as a multiple-input, multiple-output engine. Each accepted clock carries a block of three consecutive samples, and the block returns the three matching filter outputs together. It uses three copies of the multiply-add datapath. Two block-rate registers carry the last two samples of the previous block across the block boundary. The coefficients are fixed parameters. The surrounding logic does the serial-to-parallel and parallel-to-serial conversion.

A block is offered with the input valid flag high. One clock later the outputs appear in registers, with the output valid flag aligned to them. When the input valid flag is low, nothing in the filter changes.

Top module: `fir3p_top`

## Requirements
- R1: Each cycle with `in_valid` high is followed, one clock later, by `out_valid` high with the three results of that block on `out_y`. A cycle with `in_valid` low is followed by `out_valid` low.
- R2: Output lane 0 equals a·x(3k) + b·x(3k-1) + c·x(3k-2).
- R3: Output lane 1 equals a·x(3k+1) + b·x(3k) + c·x(3k-1).
- R4: Output lane 2 equals a·x(3k+2) + b·x(3k+1) + c·x(3k).
- R5: x(3k-1) and x(3k-2) come from two history registers. They hold lane 2 and lane 1 of the previously accepted block, and they are zero after reset.
- R6: While `in_valid` is low, the history registers and `out_y` keep their values. An idle gap between two blocks therefore does not change the results of the later block.
- R7: During and directly after reset, `out_valid` is 0 and every lane of `out_y` is 0.
- R8: Lanes are packed with lane j at bits [j*W +: W]. Lane 0 is the earliest sample in time. All samples, coefficients and results are two's complement. Results are DATA_W+COEF_W+2 bits wide and exact over the full input range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A three-sample block is present on `in_x` |
| in_x | input | 3*DATA_W | Samples x(3k), x(3k+1), x(3k+2) in lanes 0, 1, 2 |
| out_valid | output | 1 | `out_y` holds the results of the block accepted one clock earlier |
| out_y | output | 3*(DATA_W+COEF_W+2) | Results y(3k), y(3k+1), y(3k+2) in lanes 0, 1, 2 |

## Verification
The assertions take for granted that `in_valid` is low while reset is applied. They also assume that `in_x` is a defined two's-complement value in every cycle where `in_valid` is high. The stimulus drives both inputs on the falling edge and holds `in_valid` at 0 through every reset pulse. It sweeps each lane position over all 256 sample values and covers value pairs, alternating full-scale extremes and pseudo-random blocks. It also inserts idle gaps and a reset in the middle of the run, so that the history path is exercised both with zeros and with data carried over a gap.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;
  localparam int LANES = 3;
  localparam int TAPS  = 3;
  // bits of growth for a sum of TAPS products
  localparam int GROWTH = $clog2(TAPS) + ((TAPS & (TAPS - 1)) == 0 ? 1 : 0);
endpackage

// File: rtl/fir3p_hist.sv
module fir3p_hist #(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] last_lane,
  input  logic signed [DATA_W-1:0] mid_lane,
  output logic signed [DATA_W-1:0] q_m1,
  output logic signed [DATA_W-1:0] q_m2
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_m1 <= '0;
      q_m2 <= '0;
    end else if (load) begin
      q_m1 <= last_lane;
      q_m2 <= mid_lane;
    end
  end
endmodule

// File: rtl/fir3p_lane.sv
module fir3p_lane #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 18,
  parameter int COEF_A = 3,
  parameter int COEF_B = -5,
  parameter int COEF_C = 7
) (
  input  logic signed [DATA_W-1:0] x_cur,
  input  logic signed [DATA_W-1:0] x_m1,
  input  logic signed [DATA_W-1:0] x_m2,
  output logic signed [OUT_W-1:0]  y
);
  localparam logic signed [COEF_W-1:0] CA = COEF_W'(COEF_A);
  localparam logic signed [COEF_W-1:0] CB = COEF_W'(COEF_B);
  localparam logic signed [COEF_W-1:0] CC = COEF_W'(COEF_C);

  function automatic logic signed [OUT_W-1:0] widen_s(input logic signed [DATA_W-1:0] v);
    return OUT_W'(v);
  endfunction

  function automatic logic signed [OUT_W-1:0] widen_c(input logic signed [COEF_W-1:0] v);
    return OUT_W'(v);
  endfunction

  function automatic logic signed [OUT_W-1:0] mac3(
    input logic signed [DATA_W-1:0] s0,
    input logic signed [DATA_W-1:0] s1,
    input logic signed [DATA_W-1:0] s2
  );
    logic signed [OUT_W-1:0] acc;
    acc = widen_c(CA) * widen_s(s0);
    acc = acc + widen_c(CB) * widen_s(s1);
    acc = acc + widen_c(CC) * widen_s(s2);
    return acc;
  endfunction

  always_comb y = mac3(x_cur, x_m1, x_m2);
endmodule

// File: rtl/fir3p_top.sv
module fir3p_top
  import fir3p_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int COEF_A = 3,
  parameter int COEF_B = -5,
  parameter int COEF_C = 7,
  localparam int OUT_W = DATA_W + COEF_W + GROWTH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [LANES*DATA_W-1:0]   in_x,
  output logic                      out_valid,
  output logic [LANES*OUT_W-1:0]    out_y
);
  localparam int WIN = LANES + TAPS - 1;

  logic signed [DATA_W-1:0] win [WIN];
  logic signed [DATA_W-1:0] hist_m1;   // x(3k-1)
  logic signed [DATA_W-1:0] hist_m2;   // x(3k-2)
  logic signed [OUT_W-1:0]  lane_y [LANES];
  logic signed [OUT_W-1:0]  y_q    [LANES];
  logic                     valid_q;

  fir3p_hist #(.DATA_W(DATA_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (in_valid),
    .last_lane (in_x[(LANES-1)*DATA_W +: DATA_W]),
    .mid_lane  (in_x[(LANES-2)*DATA_W +: DATA_W]),
    .q_m1      (hist_m1),
    .q_m2      (hist_m2)
  );

  // sample window: oldest first
  assign win[0] = hist_m2;
  assign win[1] = hist_m1;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign win[j+2] = in_x[j*DATA_W +: DATA_W];

    fir3p_lane #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
      .COEF_A(COEF_A), .COEF_B(COEF_B), .COEF_C(COEF_C)
    ) u_mac (
      .x_cur (win[j+2]),
      .x_m1  (win[j+1]),
      .x_m2  (win[j]),
      .y     (lane_y[j])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)        y_q[j] <= '0;
      else if (in_valid) y_q[j] <= lane_y[j];
    end

    assign out_y[j*OUT_W +: OUT_W] = y_q[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/fir3p_chk.sv
module fir3p_chk #(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 18,
  parameter int COEF_A = 3,
  parameter int COEF_B = -5,
  parameter int COEF_C = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [3*DATA_W-1:0]   in_x,
  input logic                  out_valid,
  input logic [3*OUT_W-1:0]    out_y,
  input logic [DATA_W-1:0]     hist_m1,
  input logic [DATA_W-1:0]     hist_m2
);
  function automatic int sv(input logic [DATA_W-1:0] v);
    return int'($signed(v));
  endfunction

  int s0, s1, s2;
  logic [OUT_W-1:0] ref_l2, ref_l0;
  always_comb begin
    s0 = sv(in_x[0 +: DATA_W]);
    s1 = sv(in_x[DATA_W +: DATA_W]);
    s2 = sv(in_x[2*DATA_W +: DATA_W]);
    ref_l2 = OUT_W'(COEF_C * s0 + COEF_B * s1 + COEF_A * s2);
    ref_l0 = OUT_W'(COEF_A * s0 + COEF_B * sv(hist_m1) + COEF_C * sv(hist_m2));
  end

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_y)));

  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(hist_m1) && $stable(hist_m2)));

  assert_hist_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (hist_m1 == $past(in_x[2*DATA_W +: DATA_W]) &&
                  hist_m2 == $past(in_x[DATA_W +: DATA_W])));

  assert_lane2_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_y[2*OUT_W +: OUT_W] == $past(ref_l2)));

  assert_lane0_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_y[0 +: OUT_W] == $past(ref_l0)));
endmodule

bind fir3p_top fir3p_chk #(
  .DATA_W(DATA_W), .OUT_W(OUT_W),
  .COEF_A(COEF_A), .COEF_B(COEF_B), .COEF_C(COEF_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
  .out_valid(out_valid), .out_y(out_y),
  .hist_m1(hist_m1), .hist_m2(hist_m2)
);

// File: tb/tb_fir3p_top.sv
`timescale 1ns/1ps
module tb_fir3p_top;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = DW + CW + 2;
  localparam int KA = 3;
  localparam int KB = -5;
  localparam int KC = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [3*DW-1:0] in_x = '0;
  logic            out_valid;
  logic [3*OW-1:0] out_y;

  int n_chk = 0;
  int n_bad = 0;
  int xm1 = 0, xm2 = 0;       // sequential reference delay line
  int last_y [3] = '{0, 0, 0};
  bit done = 1'b0;

  always #4 clk = ~clk;       // 125 MHz

  fir3p_top #(.DATA_W(DW), .COEF_W(CW), .COEF_A(KA), .COEF_B(KB), .COEF_C(KC)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y)
  );

  function automatic int lane_out(input int j);
    return int'($signed(out_y[j*OW +: OW]));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // R8: lane 0 earliest; sequential reference feeds samples one by one
  task automatic send(input int a0, input int a1, input int a2);
    int smp [3];
    int exp_y [3];
    smp = '{a0, a1, a2};
    for (int j = 0; j < 3; j++) begin
      exp_y[j] = KA * smp[j] + KB * xm1 + KC * xm2;
      xm2 = xm1;
      xm1 = smp[j];
    end
    in_x = {DW'(a2), DW'(a1), DW'(a0)};
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid after block", int'(out_valid), 1);
    check("R2 lane0", lane_out(0), exp_y[0]);
    check("R3 lane1", lane_out(1), exp_y[1]);
    check("R4 lane2", lane_out(2), exp_y[2]);
    last_y = exp_y;
  endtask

  // R6: idle cycle with garbage on in_x must not disturb anything
  task automatic idle(input int junk);
    in_x = {DW'(junk), DW'(junk + 77), DW'(junk - 31)};
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 out_valid low after idle", int'(out_valid), 0);
    for (int j = 0; j < 3; j++) check("R6 out_y hold", lane_out(j), last_y[j]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 out_valid after reset", int'(out_valid), 0);
    for (int j = 0; j < 3; j++) check("R7 out_y zero", lane_out(j), 0);
    xm1 = 0;
    xm2 = 0;             // R5: history zero after reset
    last_y = '{0, 0, 0};
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int lfsr = 32'h1234_5678;
    @(negedge clk);
    do_reset();

    // R5: first block after reset sees zero history
    send(100, -7, 55);

    // impulses: every value in every lane position (R2, R3, R4, R8)
    for (int p = 0; p < 3; p++) begin
      for (int v = -128; v < 128; v++) begin
        send(p == 0 ? v : 0, p == 1 ? v : 0, p == 2 ? v : 0);
        if ((v & 15) == 3) idle(v);
      end
    end

    // value pairs crossing the block boundary (R5)
    for (int u = -128; u < 128; u += 15) begin
      for (int w = -128; w < 128; w += 17) begin
        send(u, w, -w - 1);
        send(w, u, u);
      end
    end

    // full-scale extremes (R8)
    for (int i = 0; i < 8; i++) begin
      send(-128, -128, -128);
      send(127, 127, 127);
      send(-128, 127, -128);
      idle(i);
    end

    // mid-run reset clears history (R5, R7)
    send(90, -90, 45);
    do_reset();
    send(0, 0, 0);

    // pseudo-random blocks with gaps (R6)
    for (int i = 0; i < 2000; i++) begin
      int r0, r1, r2;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >>> 17);
      lfsr = lfsr ^ (lfsr << 5);
      r0 = ((lfsr >>> 0) & 255) - 128;
      r1 = ((lfsr >>> 8) & 255) - 128;
      r2 = ((lfsr >>> 16) & 255) - 128;
      send(r0, r1, r2);
      if ((lfsr & 7) == 0) idle(r1);
    end

    finish_run();
  end
endmodule